// File: doc/BRIEF.md
# Transmit FIFO with Selectable Interrupt Level

This block is the character store that sits between a host and one UART transmitter. The host pushes characters through a write port. The serializer takes them from a first-word-fall-through pop port. A two-bit level code sets how empty the store must be before the channel asks the host for more data. The request is a level signal. It stays up for as long as the fill condition holds, and it is gated by bit 0 of the interrupt mask.

A small status word is presented on a read port. It holds four bits: threshold met, store empty, store full, and sticky overflow. A read-mode input chooses how the word is shown. With the mode at 1, the word is ANDed with the mask, so only enabled sources can show a 1. With the mode at 0, the raw status is shown regardless of the mask. A write that arrives while the store is full is discarded and sets the overflow flag. The flag stays set until a clear command.

Top module: `txfifo_irq_level`

## Requirements
- R1: After reset the store is empty and overflow is clear. The raw status word reads 4'b0011, with bit0 = threshold met, bit1 = empty, bit2 = full and bit3 = overflow. The request follows mask bit 0.
- R2: Characters leave the pop port in the order in which they were accepted. The oldest character is always visible on `pop_data` while the store is not empty.
- R3: With level code 2'b00, the threshold is met only when the store holds 0 characters.
- R4: With level code 2'b01, the threshold is met when the store holds at most DEPTH/4 characters (4 with the default depth of 16).
- R5: With level code 2'b10, the threshold is met when the store holds at most DEPTH/2 characters (8 with the default depth).
- R6: With level code 2'b11, the threshold is met whenever the store holds fewer than DEPTH characters.
- R7: `irq` equals threshold-met AND mask bit 0. It is valid from the clock edge that updates the fill level. It drops in the cycle after the write that takes the fill above the threshold.
- R8: A write to a full store is discarded and leaves the queued data unchanged. It sets status bit3. That bit then stays set through later writes and pops.
- R9: A one-cycle `clr_ovf` pulse clears status bit3 at the next edge.
- R10: When `rd_masked` is 1, `stat_view` equals the raw status ANDed with `mask`. When `rd_masked` is 0, `stat_view` equals the raw status and the mask has no effect on it.
- R11: A pop while the store is empty is ignored. The fill level stays 0, and the next written character is the next one popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DW | Character written by the host |
| pop | input | 1 | Serializer takes the oldest character |
| pop_data | output | DW | Oldest character in the store |
| tx_avail | output | 1 | Store is not empty |
| lvl_sel | input | 2 | Interrupt level code |
| mask | input | 4 | Interrupt mask, one bit per status bit |
| rd_masked | input | 1 | Status read mode: 1 masked, 0 raw |
| clr_ovf | input | 1 | Clear the sticky overflow flag |
| irq | output | 1 | Transmit interrupt request |
| stat_view | output | 4 | Status word as selected by the read mode |

## Verification
A wrong fill count shows up on `irq` and on the status empty and full bits in the cycle after the faulty write or pop. The bench sweeps every level code from 0 to 16 entries, so any off-by-one threshold is exposed on the boundary write. A corrupted pointer shows up on `pop_data` at the first pop that follows, where the scoreboard compares it with the queued character. A lost or spurious overflow bit is visible on `stat_view` one edge after the dropped write or the clear pulse.

// File: rtl/txfifo_irq_level.sv
module txfifo_irq_level #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          tx_avail,
  input  logic [1:0]    lvl_sel,
  input  logic [3:0]    mask,
  input  logic          rd_masked,
  input  logic          clr_ovf,
  output logic          irq,
  output logic [3:0]    stat_view
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] QTR_CNT  = CW'(DEPTH / 4);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          ovf;
  logic          full, empty, wr_ok, pop_ok, thr;
  logic [3:0]    raw;

  assign full   = (cnt == FULL_CNT);
  assign empty  = (cnt == '0);
  assign wr_ok  = wr_en && !full;
  assign pop_ok = pop && !empty;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (wr_ok)  wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
      if (pop_ok) rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
      case ({wr_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 ovf <= 1'b0;
    else if (clr_ovf)           ovf <= 1'b0;
    else if (wr_en && full)     ovf <= 1'b1;
  end

  always_comb begin
    case (lvl_sel)
      2'b00:   thr = empty;
      2'b01:   thr = (cnt <= QTR_CNT);
      2'b10:   thr = (cnt <= HALF_CNT);
      default: thr = !full;
    endcase
  end

  assign raw       = {ovf, full, empty, thr};
  assign stat_view = rd_masked ? (raw & mask) : raw;
  assign irq       = thr & mask[0];
  assign pop_data  = mem[rptr];
  assign tx_avail  = !empty;
endmodule

module txfifo_irq_level_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic                       pop,
  input logic                       clr_ovf,
  input logic [1:0]                 lvl_sel,
  input logic [3:0]                 mask,
  input logic                       rd_masked,
  input logic                       irq,
  input logic [3:0]                 stat_view,
  input logic [$clog2(DEPTH+1)-1:0] cnt,
  input logic                       ovf
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  a_r10_masked_view: assert property (@(posedge clk) disable iff (!rst_n)
    rd_masked |-> ((stat_view & ~mask) == 4'b0));
  a_r3_empty_only: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_sel == 2'b00 && irq) |-> (cnt == '0));
  a_r6_room_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_sel == 2'b11 && mask[0] && cnt != FULL_CNT) |-> irq);
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL_CNT && wr_en && !pop) |=> (cnt == FULL_CNT && ovf));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr_ovf) |=> ovf);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ovf |=> !ovf);
  a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && pop && !wr_en) |=> (cnt == '0));
endmodule

bind txfifo_irq_level txfifo_irq_level_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/test_txfifo_irq_level.sv
module test_txfifo_irq_level;
  localparam int DEPTH = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, pop = 1'b0, rd_masked = 1'b0, clr_ovf = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] lvl_sel = 2'b00;
  logic [3:0] mask = 4'h0;
  logic [DW-1:0] pop_data;
  logic tx_avail, irq;
  logic [3:0] stat_view;

  int checks = 0, fails = 0, model_cnt = 0;
  bit model_ovf = 0, done = 0;
  logic [DW-1:0] sb[$];

  always #2.5 clk = ~clk;

  txfifo_irq_level #(.DEPTH(DEPTH), .DW(DW)) i_txfifo_irq_level (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_thr(int c, logic [1:0] l);
    case (l)
      2'b00:   return c == 0;
      2'b01:   return c <= DEPTH / 4;
      2'b10:   return c <= DEPTH / 2;
      default: return c < DEPTH;
    endcase
  endfunction

  function automatic logic [3:0] exp_raw();
    return {model_ovf, model_cnt == DEPTH, model_cnt == 0, exp_thr(model_cnt, lvl_sel)};
  endfunction

  task automatic drive_wr(logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (model_cnt < DEPTH) begin sb.push_back(d); model_cnt++; end
    else model_ovf = 1;
  endtask

  task automatic monitor_pop(string tag);
    logic [DW-1:0] e;
    @(negedge clk);
    e = sb.pop_front();
    check(tag, pop_data, e);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    model_cnt--;
  endtask

  task automatic check_lvl(string tag);
    check(tag, irq, exp_thr(model_cnt, lvl_sel) & mask[0]);
    check(tag, stat_view, exp_raw());
  endtask

  initial begin
    string tags[4] = '{"R3", "R4", "R5", "R6"};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status", stat_view, 4'b0011);
    check("R1 irq masked off", irq, 1'b0);
    mask = 4'hF;
    #1 check("R1 irq", irq, 1'b1);

    for (int l = 0; l < 4; l++) begin
      lvl_sel = 2'(l);
      #1 check_lvl(tags[l]);
      for (int i = 0; i < DEPTH; i++) begin
        drive_wr(8'(l * 32 + i + 1));
        check_lvl({tags[l], " R7 fill"});
      end
      for (int i = 0; i < DEPTH; i++) begin
        monitor_pop({tags[l], " R2 order"});
        check_lvl({tags[l], " drain"});
      end
    end

    lvl_sel = 2'b01;
    for (int i = 0; i < DEPTH; i++) drive_wr(8'(8'h40 + i));
    drive_wr(8'hEE);
    check("R8 overflow set", stat_view[3], 1'b1);
    check("R8 still full", stat_view[2], 1'b1);
    for (int i = 0; i < DEPTH; i++) monitor_pop("R8 data unchanged");
    check("R8 sticky", stat_view, exp_raw());
    drive_wr(8'h11);
    check("R8 sticky after write", stat_view[3], 1'b1);
    @(negedge clk); clr_ovf = 1'b1;
    @(negedge clk); clr_ovf = 1'b0; model_ovf = 0;
    check("R9 cleared", stat_view[3], 1'b0);
    monitor_pop("R9 pop");

    lvl_sel = 2'b00; mask = 4'b0001; rd_masked = 1'b1;
    #1 check("R10 masked view", stat_view, 4'b0001);
    rd_masked = 1'b0;
    #1 check("R10 raw view", stat_view, 4'b0011);
    mask = 4'b0000;
    #1 check("R10 raw ignores mask", stat_view, 4'b0011);
    rd_masked = 1'b1;
    #1 check("R10 masked all off", stat_view, 4'b0000);
    rd_masked = 1'b0; mask = 4'hF;

    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
    check("R11 still empty", stat_view, 4'b0011);
    drive_wr(8'hA5);
    check("R11 tx_avail", tx_avail, 1'b1);
    monitor_pop("R11 next data");
    check("R11 empty again", stat_view, 4'b0011);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule